// File: doc/BRIEF.md
# Conversion Store Address Stepper

This block produces the memory address at which each converted analogue sample is stored, and it manages the interrupt that tells the host processor a group of samples is ready. An address is formed by placing a switch-set base above a channel index. The index starts at zero and moves up by one location for each sample in the same group, so a group lands in consecutive words. A conversion scheduler signals the end of each of its cycles together with a repeat flag. A set flag means more samples of the same group follow. A clear flag closes the group: the index returns to zero and a group interrupt is raised.

Interrupt requests stay up until the processor accepts them. On acceptance, a code that identifies the accepted source is latched into a vector register. Besides the group-end source, a set of functional trigger inputs can request interrupts that carry no conversion data. Two interlock outputs hold the scheduler. The first is high while a group interrupt waits for acceptance. The second is high after that acceptance, until software reports that it has read the stored data. While either interlock is high, end-of-cycle strobes are ignored.

Top module: `conv_store_stepper`

## Requirements
- R1: During and right after reset the index is 0, so store_addr equals the base, and irq_req, irq_vec, stall_irq, stall_mem and idx_ovf are all 0.
- R2: store_addr is base_sw in bits [14:5] and the current index (0 to 19) in bits [4:0], following base_sw at once.
- R3: A cycle_end with repeat_flag high, while not stalled, raises the index by one at that clock edge.
- R4: A cycle_end with repeat_flag low, while not stalled, returns the index to 0 and makes a group interrupt pending from the next cycle.
- R5: The index never passes 19. A repeat step taken at 19 leaves it at 19 and sets idx_ovf, which stays set until reset.
- R6: irq_req is high while any source is pending and stays high until irq_ack. One source is served per acceptance: the group source first, then the lowest-numbered functional trigger.
- R7: When irq_ack meets a high irq_req, irq_vec loads the code of the accepted source: 0 for the group end, k+1 for functional trigger k. At all other times irq_vec holds its value.
- R8: stall_irq is high while a group interrupt is pending. stall_mem rises at the edge that accepts a group interrupt and falls at the edge where mem_clr is seen. A mem_clr while stall_mem is low has no effect.
- R9: A cycle_end while stall_irq or stall_mem is high changes neither the index nor the interrupt state.
- R10: A functional trigger pulse makes its interrupt pending from the next cycle. It never raises a stall output and never moves the index. A trigger that arrives in the same cycle as its own acceptance stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sw | input | 10 | Static switch setting for the upper address bits |
| cycle_end | input | 1 | End-of-cycle strobe from the conversion scheduler |
| repeat_flag | input | 1 | High when the group continues after this cycle |
| irq_ack | input | 1 | Processor accepts the pending interrupt |
| mem_clr | input | 1 | Software pulse: stored group data has been read |
| func_trig | input | 10 | Functional trigger pulses, one per source |
| store_addr | output | 15 | Address for the current sample |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 4 | Code of the last accepted interrupt source |
| stall_irq | output | 1 | Scheduler hold: group interrupt not yet accepted |
| stall_mem | output | 1 | Scheduler hold: group data not yet cleared |
| idx_ovf | output | 1 | Sticky flag: step attempted beyond the last index |

## Verification
Long runs of repeat steps drive the index into its ceiling. This separates a correct saturating counter from one that wraps or runs past 19, and it shows whether the overflow flag stays set. Group ends mixed with functional triggers that arrive together, both while a group waits and after it, test the serving order and the vector codes one acceptance at a time. End-of-cycle strobes placed inside each stall window, and mem_clr pulses sent when nothing waits, show that held strobes and stray clears have no effect. Random sequences with a fixed seed, and base switch changes among them, then check every output each cycle against a reference model kept in the bench.

// File: rtl/css_pkg.sv
package css_pkg;

  // Saturating increment: stays at the ceiling once reached.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned last);
    return (v >= last) ? last : v + 1;
  endfunction

  // Position of the lowest set bit of a mask, 0 when empty.
  function automatic int unsigned lowest_set(input logic [31:0] m);
    for (int i = 0; i < 32; i++) begin
      if (m[i]) return i;
    end
    return 0;
  endfunction

endpackage

// File: rtl/css_index_stepper.sv
module css_index_stepper #(
  parameter int IDX_W  = 5,
  parameter int NUM_CH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             repeat_flag,
  output logic [IDX_W-1:0] idx,
  output logic             ovf,
  output logic             grp_end
);
  import css_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

  logic [IDX_W-1:0] idx_q;
  logic             ovf_q;
  logic             at_last;

  assign at_last = (idx_q == LAST);
  assign grp_end = step_en & ~repeat_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      ovf_q <= 1'b0;
    end else if (step_en) begin
      if (repeat_flag) begin
        idx_q <= IDX_W'(sat_inc(32'(idx_q), 32'(NUM_CH - 1)));
        if (at_last) ovf_q <= 1'b1;
      end else begin
        idx_q <= '0;
      end
    end
  end

  assign idx = idx_q;
  assign ovf = ovf_q;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);  // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);  // R5
  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && repeat_flag && !at_last) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));  // R3
  AST_GRP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    grp_end |=> (idx_q == '0));  // R4

endmodule

// File: rtl/css_irq_arbiter.sv
module css_irq_arbiter #(
  parameter int NUM_FT = 10,
  parameter int SRC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_end,
  input  logic [NUM_FT-1:0] func_trig,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [SRC_W-1:0]  irq_vec,
  output logic              grp_pend,
  output logic              grp_accept
);
  import css_pkg::*;

  logic              grp_pend_q;
  logic [NUM_FT-1:0] ft_pend_q;
  logic [NUM_FT-1:0] ft_clr;
  logic [SRC_W-1:0]  vec_q;
  logic [SRC_W-1:0]  win_code;
  logic              any_pend;
  logic              accept;

  always_comb begin
    any_pend = grp_pend_q | (|ft_pend_q);
    win_code = grp_pend_q ? '0 : SRC_W'(lowest_set(32'(ft_pend_q)) + 1);
    accept   = irq_ack & any_pend;
    // isolate the lowest pending trigger for clearing
    ft_clr   = (accept && !grp_pend_q) ? (ft_pend_q & (~ft_pend_q + 1'b1)) : '0;
  end

  assign grp_accept = accept & grp_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_pend_q <= 1'b0;
      ft_pend_q  <= '0;
      vec_q      <= '0;
    end else begin
      grp_pend_q <= (grp_pend_q & ~grp_accept) | grp_end;
      ft_pend_q  <= (ft_pend_q & ~ft_clr) | func_trig;
      if (accept) vec_q <= win_code;
    end
  end

  assign irq_req  = any_pend;
  assign irq_vec  = vec_q;
  assign grp_pend = grp_pend_q;

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> irq_req);  // R6
  AST_GRP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_pend_q && irq_ack) |=> (irq_vec == '0));  // R6
  AST_VEC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_ack && irq_req) |=> $stable(irq_vec));  // R7
  AST_TRIG_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|func_trig) |=> irq_req);  // R10

endmodule

// File: rtl/css_interlock.sv
module css_interlock (
  input  logic clk,
  input  logic rst_n,
  input  logic grp_pend,
  input  logic grp_accept,
  input  logic mem_clr,
  output logic stall_irq,
  output logic stall_mem
);
  logic wait_clr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          wait_clr_q <= 1'b0;
    else if (grp_accept) wait_clr_q <= 1'b1;
    else if (mem_clr)    wait_clr_q <= 1'b0;
  end

  assign stall_irq = grp_pend;
  assign stall_mem = wait_clr_q;

  AST_MEM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    grp_accept |=> stall_mem);  // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_mem && !mem_clr) |=> stall_mem);  // R8
  AST_MEM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_mem && mem_clr && !grp_accept) |=> !stall_mem);  // R8

endmodule

// File: rtl/conv_store_stepper.sv
module conv_store_stepper #(
  parameter int BASE_W = 10,
  parameter int IDX_W  = 5,
  parameter int NUM_CH = 20,
  parameter int NUM_FT = 10,
  parameter int SRC_W  = $clog2(NUM_FT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BASE_W-1:0]       base_sw,
  input  logic                    cycle_end,
  input  logic                    repeat_flag,
  input  logic                    irq_ack,
  input  logic                    mem_clr,
  input  logic [NUM_FT-1:0]       func_trig,
  output logic [BASE_W+IDX_W-1:0] store_addr,
  output logic                    irq_req,
  output logic [SRC_W-1:0]        irq_vec,
  output logic                    stall_irq,
  output logic                    stall_mem,
  output logic                    idx_ovf
);
  localparam int ADDR_W = BASE_W + IDX_W;

  function automatic logic [ADDR_W-1:0] make_addr(input logic [BASE_W-1:0] b,
                                                  input logic [IDX_W-1:0]  i);
    return {b, i};
  endfunction

  // named internal events
  logic             stall_any;
  logic             step_en;
  logic             grp_end;
  logic             grp_pend;
  logic             grp_accept;
  logic [IDX_W-1:0] idx;

  assign stall_any = stall_irq | stall_mem;
  assign step_en   = cycle_end & ~stall_any;

  css_index_stepper #(.IDX_W(IDX_W), .NUM_CH(NUM_CH)) u_step (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .repeat_flag(repeat_flag),
    .idx(idx), .ovf(idx_ovf), .grp_end(grp_end)
  );

  css_irq_arbiter #(.NUM_FT(NUM_FT), .SRC_W(SRC_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .grp_end(grp_end), .func_trig(func_trig),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
    .grp_pend(grp_pend), .grp_accept(grp_accept)
  );

  css_interlock u_lock (
    .clk(clk), .rst_n(rst_n), .grp_pend(grp_pend), .grp_accept(grp_accept),
    .mem_clr(mem_clr), .stall_irq(stall_irq), .stall_mem(stall_mem)
  );

  assign store_addr = make_addr(base_sw, idx);

  AST_STALL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_any |=> $stable(idx));  // R9
  AST_NO_NEW_GRP: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_any && !irq_ack) |=> (grp_pend == $past(grp_pend)));  // R9
  AST_ADDR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    store_addr[ADDR_W-1:IDX_W] == base_sw);  // R2

endmodule

// File: tb/test_conv_store_stepper.sv
module test_conv_store_stepper;
  localparam int BASE_W = 10;
  localparam int IDX_W  = 5;
  localparam int NUM_CH = 20;
  localparam int NUM_FT = 10;
  localparam int SRC_W  = 4;
  localparam int ADDR_W = BASE_W + IDX_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic [BASE_W-1:0] base_sw;
  logic              cycle_end, repeat_flag, irq_ack, mem_clr;
  logic [NUM_FT-1:0] func_trig;
  logic [ADDR_W-1:0] store_addr;
  logic              irq_req, stall_irq, stall_mem, idx_ovf;
  logic [SRC_W-1:0]  irq_vec;

  conv_store_stepper i_conv_store_stepper (
    .clk(clk), .rst_n(rst_n), .base_sw(base_sw), .cycle_end(cycle_end),
    .repeat_flag(repeat_flag), .irq_ack(irq_ack), .mem_clr(mem_clr),
    .func_trig(func_trig), .store_addr(store_addr), .irq_req(irq_req),
    .irq_vec(irq_vec), .stall_irq(stall_irq), .stall_mem(stall_mem),
    .idx_ovf(idx_ovf)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int unsigned       m_idx;
  bit                m_ovf, m_pg, m_wc;
  logic [NUM_FT-1:0] m_pft;
  int unsigned       m_vec;

  function automatic int unsigned exp_code(bit pg, logic [NUM_FT-1:0] pft);
    if (pg) return 0;
    for (int k = 0; k < NUM_FT; k++) if (pft[k]) return k + 1;
    return 0;
  endfunction

  function automatic longint exp_addr(logic [BASE_W-1:0] b, int unsigned i);
    return longint'(b) * (1 << IDX_W) + i;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_idx = 0; m_ovf = 0; m_pg = 0; m_wc = 0; m_pft = '0; m_vec = 0;
  endtask

  task automatic cyc(bit ce, bit rep, bit ack, bit mc,
                     logic [NUM_FT-1:0] ft, logic [BASE_W-1:0] b);
    bit stall, acc, new_pg;
    int unsigned code;
    string tag;
    @(negedge clk);
    cycle_end = ce; repeat_flag = rep; irq_ack = ack; mem_clr = mc;
    func_trig = ft; base_sw = b;
    stall  = m_pg | m_wc;
    acc    = ack && (m_pg || (|m_pft));
    code   = exp_code(m_pg, m_pft);
    new_pg = 0;
    tag    = "R2";
    if (ce && stall) tag = "R9";
    else if (ce && rep) begin
      if (m_idx == NUM_CH - 1) begin m_ovf = 1; tag = "R5"; end
      else begin m_idx++; tag = "R3"; end
    end else if (ce) begin
      m_idx = 0; new_pg = 1; tag = "R4";
    end else if (|ft) tag = "R10";
    if (acc && code == 0) m_wc = 1;
    else if (mc) m_wc = 0;
    if (acc && code != 0) m_pft[code-1] = 1'b0;
    m_pft = m_pft | ft;
    m_pg  = (m_pg && !(acc && code == 0)) || new_pg;
    if (acc) m_vec = code;
    @(posedge clk); #1;
    chk(tag,        store_addr, exp_addr(b, m_idx));
    chk("R6 irq",   irq_req,    longint'(m_pg || (|m_pft)));
    chk("R7 vec",   irq_vec,    m_vec);
    chk("R8 stall_irq", stall_irq, m_pg);
    chk("R8 stall_mem", stall_mem, m_wc);
    chk("R5 ovf",   idx_ovf,    m_ovf);
  endtask

  task automatic do_reset(logic [BASE_W-1:0] b);
    @(negedge clk);
    rst_n = 0; cycle_end = 0; repeat_flag = 0; irq_ack = 0; mem_clr = 0;
    func_trig = '0; base_sw = b;
    repeat (2) @(negedge clk);
    model_reset();
    chk("R1 addr", store_addr, exp_addr(b, 0));
    chk("R1 irq",  irq_req, 0);
    chk("R1 vec",  irq_vec, 0);
    chk("R1 stall", longint'(stall_irq | stall_mem), 0);
    chk("R1 ovf",  idx_ovf, 0);
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'h5A17));
    do_reset(10'h2A5);
    cyc(0, 0, 0, 0, '0, 10'h2A5);
    // walk into the ceiling (R3, R5)
    for (int i = 0; i < 22; i++) cyc(1, 1, 0, 0, '0, 10'h2A5);
    cyc(0, 0, 0, 0, '0, 10'h155);            // R2 base follows switches
    cyc(1, 0, 0, 0, '0, 10'h155);            // R4 group end
    cyc(1, 1, 0, 0, '0, 10'h155);            // R9 ignored while pending
    cyc(0, 0, 0, 1, 10'b0000001000, 10'h155); // R10 trigger, stray mem_clr
    cyc(0, 0, 1, 0, '0, 10'h155);            // R6 group served first
    cyc(1, 1, 0, 0, '0, 10'h155);            // R9 ignored while waiting clear
    cyc(0, 0, 1, 0, '0, 10'h155);            // R7 trigger 3 -> code 4
    cyc(0, 0, 0, 1, '0, 10'h155);            // R8 clear
    cyc(1, 1, 0, 0, '0, 10'h155);            // R3 stepping again
    cyc(0, 0, 0, 0, 10'b0000100100, 10'h155); // two triggers together
    cyc(0, 0, 1, 0, 10'b0000000100, 10'h155); // R10 re-raise on acceptance
    cyc(0, 0, 1, 0, '0, 10'h155);
    cyc(0, 0, 1, 0, '0, 10'h155);
    cyc(0, 0, 1, 1, '0, 10'h155);            // R8 mem_clr with nothing waiting
    do_reset(10'h0F0);                       // R1 ovf cleared by reset
    for (int i = 0; i < 4000; i++) begin
      logic [BASE_W-1:0] b;
      logic [NUM_FT-1:0] ft;
      b  = ($urandom % 16 == 0) ? BASE_W'($urandom) : base_sw;
      ft = ($urandom % 10 == 0) ? NUM_FT'(1 << ($urandom % NUM_FT)) : '0;
      cyc($urandom % 3 == 0, $urandom % 8 != 0, $urandom % 4 == 0,
          $urandom % 5 == 0, ft, b);
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule